// File: doc/BRIEF.md
# Programmable Periodic Rate Divider

This block turns a free-running reference oscillator into three timing outputs: a sticky periodic flag with an interrupt request, a square-wave pin, and a single-cycle one-second strobe for a time-keeping update controller. The oscillator is presented as a clock-enable pulse, `osc_en`, on the system clock. A 3-bit reference code chooses how many oscillator pulses make one base tick, so that three oscillator frequencies all give the same base rate. Some codes stop the chain and hold it at a known phase. A 4-bit rate code picks a power-of-two tap of the divider chain. That tap drives both the periodic flag and the square-wave pin.

A small phase machine follows the divider. `PH_HOLD` is entered from any state when the reference code is a hold code or an unsupported code. `PH_HOLD` moves to `PH_WARM` on the first clock edge that sees a valid reference code. `PH_WARM` moves to `PH_RUN` when the first one-second strobe fires. `PH_RUN` stays in place until a hold code appears. The chain counts only outside `PH_HOLD`. It is preloaded at half of its span, so the first strobe after a release arrives half a second later.

Top module: `periodic_rate_divider`

## Requirements
- R1: `div_ctl` code 3'b000 makes one base tick every 2^FAST_LOG2 (128) `osc_en` pulses, code 3'b001 every 2^MID_LOG2 (32) pulses, and code 3'b010 on every pulse.
- R2: Codes 3'b110 and 3'b111 are hold codes, and the unsupported codes 3'b011, 3'b100 and 3'b101 act the same way. While any of them is applied, the prescaler and the chain are cleared to their start values, `pf_flag` never rises and `sec_tick` stays low.
- R3: When `rate_sel` is 0, `pf_flag` never rises and `sqw_out` stays low.
- R4: For `rate_sel` r from 1 to 15, the periodic event occurs once every 2^(r-1) base ticks. Code 1 therefore fires on every base tick, and code 15 fires once per 16384 base ticks.
- R5: `pf_flag` sets on each periodic event whether or not `pie_en` is set. It stays set until a clock edge that sees `pf_clr` high. A set and a clear on the same edge leave the flag set.
- R6: `irq_pend` is high exactly when `pf_flag` and `pie_en` are both high.
- R7: For r of 2 or more, `sqw_out` is a 50% duty wave with a period of 2^(r-1) base ticks. It rises one clock after the `pf_flag` set edge. Code 1 drives the pin at the code-2 rate. The pin is low one clock after `sqw_en` is 0 or `rate_sel` is 0.
- R8: `sec_tick` is a one-clock pulse. After a hold code gives way to a valid code, the first pulse follows 2^(STAGES-1) base ticks, and the first base tick can come no earlier than the second clock edge after the release. Later pulses follow every 2^STAGES base ticks. The same timing applies after every release, including a release from a hold entered while running.
- R9: While `rst_n` is low, `pf_flag`, `irq_pend`, `sqw_out` and `sec_tick` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One pulse per reference oscillator cycle |
| div_ctl | input | 3 | Reference select and hold code |
| rate_sel | input | RATE_W (4) | Periodic tap select, 0 means off |
| pie_en | input | 1 | Lets the flag raise `irq_pend` |
| sqw_en | input | 1 | Enables the square-wave pin |
| pf_clr | input | 1 | Clears the periodic flag (read side effect) |
| pf_flag | output | 1 | Sticky periodic event flag |
| irq_pend | output | 1 | Periodic interrupt request |
| sqw_out | output | 1 | Square-wave pin |
| sec_tick | output | 1 | One-second strobe for the update controller |

## Verification
The hardest case to reach from the ports is the half-second phase after a release, because it shows only in the arrival time of a strobe tens of thousands of base ticks later. To reach it, the reference code that needs no prescale is used and the oscillator enable is held high, so each base tick is one clock. The stimulus then releases the chain from an unsupported code and counts clock edges to the first strobe and to the next one. It then forces a hold with a different code while the machine is in `PH_RUN`, releases again, and expects the same half-second delay. Every rate code from 2 to 15 is also swept, and the measured flag period and square-wave high time are compared with powers of two.

// File: rtl/prd_pkg.sv
package prd_pkg;

    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_WARM = 2'd1,
        PH_RUN  = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        REF_FAST = 2'd0,
        REF_MID  = 2'd1,
        REF_SLOW = 2'd2,
        REF_NONE = 2'd3
    } ref_t;

    // Hold codes and unsupported codes both map to REF_NONE.
    function automatic ref_t decode_ref(input logic [2:0] code);
        case (code)
            3'b000:  return REF_FAST;
            3'b001:  return REF_MID;
            3'b010:  return REF_SLOW;
            default: return REF_NONE;
        endcase
    endfunction

endpackage

// File: rtl/prd_prescaler.sv
module prd_prescaler
    import prd_pkg::*;
#(
    parameter int FAST_LOG2 = 7,
    parameter int MID_LOG2  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic run,
    input  ref_t mode,
    output logic base_tick
);

    localparam logic [FAST_LOG2-1:0] MID_MASK = FAST_LOG2'((1 << MID_LOG2) - 1);

    logic [FAST_LOG2-1:0] cnt_q;
    logic                 match;

    always_comb begin
        unique case (mode)
            REF_FAST: match = &cnt_q;
            REF_MID:  match = ((cnt_q & MID_MASK) == MID_MASK);
            REF_SLOW: match = 1'b1;
            default:  match = 1'b0;
        endcase
    end

    assign base_tick = run & osc_en & match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (osc_en) begin
            cnt_q <= cnt_q + FAST_LOG2'(1);
        end
    end

endmodule

// File: rtl/prd_chain.sv
module prd_chain #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [STAGES-2:0] chain_lo,
    output logic [STAGES-2:0] rise_lo,
    output logic              wrap
);

    // Preset to half span: the first wrap comes half a second after release.
    localparam logic [STAGES-1:0] PRESET = STAGES'(1) << (STAGES - 1);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] nxt;

    assign nxt      = chain_q + STAGES'(1);
    assign chain_lo = chain_q[STAGES-2:0];
    assign rise_lo  = step ? (nxt[STAGES-2:0] & ~chain_q[STAGES-2:0]) : '0;
    assign wrap     = step & (&chain_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= PRESET;
        end else if (load) begin
            chain_q <= PRESET;
        end else if (step) begin
            chain_q <= nxt;
        end
    end

endmodule

// File: rtl/prd_tap_mux.sv
module prd_tap_mux #(
    parameter int STAGES = 15,
    parameter int RATE_W = 4
) (
    input  logic [RATE_W-1:0] rate,
    input  logic [STAGES-2:0] chain_lo,
    input  logic [STAGES-2:0] rise_lo,
    input  logic              step,
    output logic              pf_set,
    output logic              level
);

    localparam int CODES = 1 << RATE_W;

    logic [CODES-1:0] set_by_code;
    logic [CODES-1:0] lvl_by_code;

    assign set_by_code[0] = 1'b0;
    assign lvl_by_code[0] = 1'b0;
    assign set_by_code[1] = step;
    assign lvl_by_code[1] = chain_lo[0];

    for (genvar g = 2; g < CODES; g++) begin : g_tap
        localparam int BIT = ((g - 2) > (STAGES - 2)) ? (STAGES - 2) : (g - 2);
        assign set_by_code[g] = rise_lo[BIT];
        assign lvl_by_code[g] = chain_lo[BIT];
    end

    assign pf_set = set_by_code[rate];
    assign level  = lvl_by_code[rate];

endmodule

// File: rtl/periodic_rate_divider.sv
module periodic_rate_divider
    import prd_pkg::*;
#(
    parameter int STAGES    = 15,
    parameter int FAST_LOG2 = 7,
    parameter int MID_LOG2  = 5,
    parameter int RATE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic [2:0]        div_ctl,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              pie_en,
    input  logic              sqw_en,
    input  logic              pf_clr,
    output logic              pf_flag,
    output logic              irq_pend,
    output logic              sqw_out,
    output logic              sec_tick
);

    phase_t phase_q;
    phase_t phase_d;
    ref_t   ref_mode;
    logic   code_ok;
    logic   run;
    logic   chain_load;
    logic   base_tick;
    logic   sec_set;
    logic   pf_set;
    logic   tap_level;
    logic   pin_en;
    logic   pf_q;
    logic   sqw_q;
    logic   sec_q;

    logic [STAGES-2:0] chain_lo;
    logic [STAGES-2:0] rise_lo;

    assign ref_mode = decode_ref(div_ctl);
    assign code_ok  = (ref_mode != REF_NONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_HOLD;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_HOLD: if (code_ok) phase_d = PH_WARM;
            PH_WARM: begin
                if (!code_ok)     phase_d = PH_HOLD;
                else if (sec_set) phase_d = PH_RUN;
            end
            PH_RUN:  if (!code_ok) phase_d = PH_HOLD;
            default: phase_d = PH_HOLD;
        endcase
    end

    // Outputs of the phase machine
    always_comb begin
        run        = code_ok && (phase_q != PH_HOLD);
        chain_load = !run;
        pin_en     = sqw_en && (rate_sel != '0);
    end

    prd_prescaler #(
        .FAST_LOG2 (FAST_LOG2),
        .MID_LOG2  (MID_LOG2)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_en    (osc_en),
        .run       (run),
        .mode      (ref_mode),
        .base_tick (base_tick)
    );

    prd_chain #(
        .STAGES (STAGES)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (chain_load),
        .step     (base_tick),
        .chain_lo (chain_lo),
        .rise_lo  (rise_lo),
        .wrap     (sec_set)
    );

    prd_tap_mux #(
        .STAGES (STAGES),
        .RATE_W (RATE_W)
    ) u_tap (
        .rate     (rate_sel),
        .chain_lo (chain_lo),
        .rise_lo  (rise_lo),
        .step     (base_tick),
        .pf_set   (pf_set),
        .level    (tap_level)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_q  <= 1'b0;
            sqw_q <= 1'b0;
            sec_q <= 1'b0;
        end else begin
            pf_q  <= pf_set | (pf_q & ~pf_clr);
            sqw_q <= pin_en & tap_level;
            sec_q <= sec_set;
        end
    end

    assign pf_flag  = pf_q;
    assign irq_pend = pf_q & pie_en;
    assign sqw_out  = sqw_q;
    assign sec_tick = sec_q;

endmodule

// File: rtl/prd_checker.sv
module prd_checker #(
    parameter int RATE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        div_ctl,
    input logic [RATE_W-1:0] rate_sel,
    input logic              sqw_en,
    input logic              pf_clr,
    input logic              pf_flag,
    input logic              sqw_out,
    input logic              sec_tick
);

    logic hold_code;
    assign hold_code = (div_ctl[2] | (div_ctl[1] & div_ctl[0]));

    p_hold_no_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_code |=> !$rose(pf_flag));

    p_hold_no_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_code |=> !sec_tick);

    p_rate_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> !$rose(pf_flag));

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_flag && !pf_clr) |=> pf_flag);

    p_pin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sqw_en || rate_sel == '0) |=> !sqw_out);

    p_second_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

endmodule

bind periodic_rate_divider prd_checker #(.RATE_W(RATE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_ctl  (div_ctl),
    .rate_sel (rate_sel),
    .sqw_en   (sqw_en),
    .pf_clr   (pf_clr),
    .pf_flag  (pf_flag),
    .sqw_out  (sqw_out),
    .sec_tick (sec_tick)
);

// File: tb/periodic_rate_divider_tb.sv
module periodic_rate_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       osc_en;
    logic [2:0] div_ctl;
    logic [3:0] rate_sel;
    logic       pie_en;
    logic       sqw_en;
    logic       pf_clr;
    logic       pf_flag;
    logic       irq_pend;
    logic       sqw_out;
    logic       sec_tick;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    periodic_rate_divider u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .div_ctl  (div_ctl),
        .rate_sel (rate_sel),
        .pie_en   (pie_en),
        .sqw_en   (sqw_en),
        .pf_clr   (pf_clr),
        .pf_flag  (pf_flag),
        .irq_pend (irq_pend),
        .sqw_out  (sqw_out),
        .sec_tick (sec_tick)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic sync_rise(output bit seen);
        logic prev;
        prev = pf_flag;
        seen = 1'b0;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            if (!prev && pf_flag) begin
                seen = 1'b1;
                break;
            end
            prev = pf_flag;
        end
    endtask

    // Period between flag rises and the sqw high samples inside it.
    task automatic measure(output int per, output int hi);
        bit   seen;
        logic prev;
        per = 0;
        hi  = 0;
        sync_rise(seen);
        if (seen) begin
            prev = 1'b1;
            for (int i = 0; i < 70000; i++) begin
                @(negedge clk);
                per++;
                if (sqw_out) hi++;
                if (!prev && pf_flag) break;
                prev = pf_flag;
            end
        end
    endtask

    task automatic window(input int n, output int rises, output int hi,
                          output int flag_hi, output int secs);
        logic prev;
        prev    = pf_flag;
        rises   = 0;
        hi      = 0;
        flag_hi = 0;
        secs    = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!prev && pf_flag) rises++;
            if (sqw_out)  hi++;
            if (pf_flag)  flag_hi++;
            if (sec_tick) secs++;
            prev = pf_flag;
        end
    endtask

    task automatic wait_sec(output int n);
        n = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            n++;
            if (sec_tick) break;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        int per, hi, rises, fhi, secs, n, irq_hi;
        rst_n    = 1'b0;
        osc_en   = 1'b1;
        div_ctl  = 3'b010;
        rate_sel = 4'd0;
        pie_en   = 1'b0;
        sqw_en   = 1'b1;
        pf_clr   = 1'b1;

        // R9: outputs quiet in reset
        repeat (3) @(negedge clk);
        chk(!pf_flag && !irq_pend && !sqw_out && !sec_tick, "R9 reset outputs",
            int'({pf_flag, irq_pend, sqw_out, sec_tick}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pf_flag && !sqw_out && !sec_tick, "R9 after release",
            int'({pf_flag, sqw_out, sec_tick}), 0);

        // R4 and R7: sweep of rate codes 2..15 with one clock per base tick
        for (int r = 2; r <= 15; r++) begin
            rate_sel = 4'(r);
            measure(per, hi);
            chk(per == (1 << (r - 1)), $sformatf("R4 period code %0d", r), per, 1 << (r - 1));
            chk(hi == (1 << (r - 2)), $sformatf("R7 duty code %0d", r), hi, 1 << (r - 2));
        end

        // R1: prescale per reference code
        div_ctl  = 3'b001;
        rate_sel = 4'd3;
        measure(per, hi);
        chk(per == 4 * 32, "R1 mid reference", per, 128);
        div_ctl  = 3'b000;
        rate_sel = 4'd2;
        measure(per, hi);
        chk(per == 2 * 128, "R1 fast reference", per, 256);
        div_ctl  = 3'b001;
        rate_sel = 4'd1;
        measure(per, hi);
        chk(per == 32, "R4 code 1 every base tick", per, 32);

        // R5 / R6: sticky flag, pie gating
        div_ctl  = 3'b010;
        rate_sel = 4'd10;
        pf_clr   = 1'b0;
        @(negedge clk);
        sync_rise(bit'(n));
        irq_hi = 0;
        fhi    = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pf_flag)  fhi++;
            if (irq_pend) irq_hi++;
        end
        chk(fhi == 40, "R5 flag sticky with pie off", fhi, 40);
        chk(irq_hi == 0, "R6 no irq with pie off", irq_hi, 0);
        pie_en = 1'b1;
        @(negedge clk);
        chk(irq_pend == 1'b1, "R6 irq with pie on", int'(irq_pend), 1);
        pf_clr = 1'b1;
        @(negedge clk);
        pf_clr = 1'b0;
        @(negedge clk);
        chk(pf_flag == 1'b0, "R5 clear", int'(pf_flag), 0);
        chk(irq_pend == 1'b0, "R6 irq follows clear", int'(irq_pend), 0);
        pf_clr   = 1'b1;
        rate_sel = 4'd1;
        repeat (2) @(negedge clk);
        window(20, rises, hi, fhi, secs);
        chk(fhi == 20, "R5 set wins over clear", fhi, 20);
        pie_en = 1'b0;

        // R3: rate off
        rate_sel = 4'd0;
        repeat (3) @(negedge clk);
        window(200, rises, hi, fhi, secs);
        chk(rises == 0, "R3 no flag with rate off", rises, 0);
        chk(hi == 0, "R3 pin low with rate off", hi, 0);

        // R7: pin disabled
        sqw_en   = 1'b0;
        rate_sel = 4'd4;
        repeat (2) @(negedge clk);
        window(100, rises, hi, fhi, secs);
        chk(hi == 0, "R7 pin low when disabled", hi, 0);
        chk(rises > 0, "R7 flag still runs when pin disabled", rises, 12);
        sqw_en = 1'b1;

        // R2: hold and unsupported codes
        rate_sel = 4'd2;
        div_ctl  = 3'b110;
        repeat (2) @(negedge clk);
        window(300, rises, hi, fhi, secs);
        chk(rises == 0 && secs == 0, "R2 hold code 110", rises + secs, 0);
        div_ctl = 3'b101;
        repeat (2) @(negedge clk);
        window(300, rises, hi, fhi, secs);
        chk(rises == 0 && secs == 0, "R2 unsupported code 101", rises + secs, 0);
        div_ctl = 3'b011;
        repeat (2) @(negedge clk);
        window(300, rises, hi, fhi, secs);
        chk(rises == 0 && secs == 0, "R2 unsupported code 011", rises + secs, 0);

        // R8: half-second phase after release, then full period
        div_ctl = 3'b010;
        wait_sec(n);
        chk(n == 16385, "R8 first strobe after release", n, 16385);
        wait_sec(n);
        chk(n == 32768, "R8 strobe period", n, 32768);
        div_ctl = 3'b111;
        repeat (3) @(negedge clk);
        div_ctl = 3'b010;
        wait_sec(n);
        chk(n == 16385, "R8 first strobe after re-hold", n, 16385);

        report();
        $finish;
    end

endmodule